// File: doc/BRIEF.md
# Triple-Oversampled Serial Data Recovery Loop

This block recovers a serial bit stream that has been sampled three times per bit by an external multiphase sampler. Each clock cycle it takes a 12-sample word covering four serial bits. It keeps that word for one cycle so that the first sample of the following word is available. A selectable window views the held word in one of three ways: shifted one sample earlier, unshifted, or shifted one sample later. The middle sample of each three-sample group is taken as a recovered bit.

Each group of three window samples is checked for a transition near its edges, which gives a vote to move the window earlier or later. The four group votes are combined by a two-of-four majority. A run-length loop filter turns the majority into a single move request only after a sustained run. A three-state rotating phase register then applies that request to the window. The loop therefore follows slow drift and channel skew without counting transitions across all sampling phases.

Top module: `dpll_cdr`

## Requirements
- R1: With the phase at the unshifted setting, window sample A[n] equals held sample S[n]. Recovered bit data_o[k] is A[3k+1]. A word presented on samp_i (bit 0 is the earliest sample) is held at the next rising edge, and its recovered bits are visible on data_o during the following cycle.
- R2: phase_o is always one-hot. 3'b100 means the earlier shift, 3'b010 means unshifted and 3'b001 means the later shift.
- R3: In the earlier shift, A[0] is the last sample of the word held before the current one, and A[n] = S[n-1] for n ≥ 1.
- R4: In the later shift, A[n] = S[n+1] for n ≤ 10, and A[11] is samp_i[0], the first sample of the word now arriving.
- R5: Each group n is read as the pattern A[3n],A[3n+1],A[3n+2], first sample on the left. 011 and 100 vote to move later (up). 001 and 110 vote to move earlier (down). 000, 111, 010 and 101 cast no vote.
- R6: The up majority is true when at least two of the four groups vote up. The down majority is formed the same way from the down votes.
- R7: up_o is 1 for one cycle in the fourth consecutive cycle in which the up majority is true and the down majority is false. dn_o behaves the same way for down. In every other cycle hold_o is 1 and both up_o and dn_o are 0. A cycle in which both majorities are true counts as a hold.
- R8: Moves take effect at the rising edge that ends the cycle in which the request is asserted. Up rotates 100→010→001→100 and down rotates 001→010→100→001. The window uses the new phase from the next cycle on.
- R9: Both run counters clear after either request fires. A cycle that breaks a run clears that run's counter, so a fresh run of four is needed.
- R10: A synchronous active-high reset sets phase_o to 3'b010, clears the run counters and clears the held word and the held last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | 12 | Oversampled word, bit 0 earliest |
| data_o | output | 4 | Recovered bits, bit 0 earliest |
| phase_o | output | 3 | One-hot window phase |
| up_o | output | 1 | Filtered move-later request |
| dn_o | output | 1 | Filtered move-earlier request |
| hold_o | output | 1 | No move this cycle |

## Verification
The assertions assume that samp_i always carries defined logic levels and that reset is applied before the first word matters. The run-length and rotation properties look back only over cycles after reset. The stimulus drives reset from time zero and gives samp_i a defined word in every cycle: first the eight group patterns repeated in all groups, then mixed-vote and run-breaking words, then long one-sided runs that walk the phase round in both directions, and finally pseudo-random words.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int unsigned OSR       = 3;
    localparam int unsigned DEF_NBITS = 4;
    localparam int unsigned DEF_RUN   = 4;

    typedef enum logic [2:0] {
        PH_EARLY = 3'b100,
        PH_MID   = 3'b010,
        PH_LATE  = 3'b001
    } phase_e;

    typedef struct packed {
        logic up;
        logic dn;
    } vote_t;

    // g = {first, middle, last} sample of one group
    function automatic vote_t judge(input logic [2:0] g);
        vote_t v;
        v.up = (g == 3'b011) || (g == 3'b100);
        v.dn = (g == 3'b001) || (g == 3'b110);
        return v;
    endfunction

    function automatic phase_e rot_up(input phase_e p);
        case (p)
            PH_EARLY: return PH_MID;
            PH_MID:   return PH_LATE;
            default:  return PH_EARLY;
        endcase
    endfunction

    function automatic phase_e rot_dn(input phase_e p);
        case (p)
            PH_LATE:  return PH_MID;
            PH_MID:   return PH_EARLY;
            default:  return PH_LATE;
        endcase
    endfunction

endpackage

// File: rtl/dpll_window.sv
module dpll_window
    import dpll_pkg::*;
#(
    parameter int unsigned NBITS = DEF_NBITS
) (
    input  logic [OSR*NBITS-1:0] cur,
    input  logic                 sp,
    input  logic                 sn,
    input  phase_e               phase,
    output logic [OSR*NBITS-1:0] aligned
);
    localparam int unsigned W = OSR * NBITS;

    always_comb begin
        case (phase)
            PH_EARLY: aligned = {cur[W-2:0], sp};
            PH_LATE:  aligned = {sn, cur[W-1:1]};
            default:  aligned = cur;
        endcase
    end
endmodule

// File: rtl/dpll_detect.sv
module dpll_detect
    import dpll_pkg::*;
#(
    parameter int unsigned NBITS = DEF_NBITS
) (
    input  logic [OSR*NBITS-1:0] aligned,
    output logic                 upf,
    output logic                 dnf
);
    localparam int unsigned CW  = $clog2(NBITS + 1);
    localparam int unsigned MAJ = NBITS / 2;

    logic [NBITS-1:0] up_bits, dn_bits;
    logic [CW-1:0]    n_up, n_dn;

    for (genvar n = 0; n < NBITS; n++) begin : g_cell
        vote_t v;
        assign v = judge({aligned[OSR*n], aligned[OSR*n+1], aligned[OSR*n+2]});
        assign up_bits[n] = v.up;
        assign dn_bits[n] = v.dn;
    end

    always_comb begin
        n_up = '0;
        n_dn = '0;
        for (int i = 0; i < NBITS; i++) begin
            n_up = n_up + CW'(up_bits[i]);
            n_dn = n_dn + CW'(dn_bits[i]);
        end
    end

    assign upf = (n_up >= CW'(MAJ));
    assign dnf = (n_dn >= CW'(MAJ));
endmodule

// File: rtl/dpll_filter.sv
module dpll_filter
    import dpll_pkg::*;
#(
    parameter int unsigned RUN = DEF_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic upf,
    input  logic dnf,
    output logic upt,
    output logic dnt,
    output logic hold
);
    localparam int unsigned CW = (RUN > 1) ? $clog2(RUN) : 1;

    logic [CW-1:0] up_cnt, dn_cnt;
    logic          up_only, dn_only;

    assign up_only = upf & ~dnf;
    assign dn_only = dnf & ~upf;
    assign upt     = up_only && (up_cnt == CW'(RUN - 1));
    assign dnt     = dn_only && (dn_cnt == CW'(RUN - 1));
    assign hold    = ~(upt | dnt);

    always_ff @(posedge clk) begin
        if (rst || upt || dnt) begin
            up_cnt <= '0;
            dn_cnt <= '0;
        end else begin
            up_cnt <= up_only ? up_cnt + 1'b1 : '0;
            dn_cnt <= dn_only ? dn_cnt + 1'b1 : '0;
        end
    end

    // R7: requests are exclusive
    p_excl_req_r7: assert property (@(posedge clk) disable iff (rst)
        !(upt && dnt));
    // R7: an up request closes a run of at least two one-sided cycles
    p_up_run_r7: assert property (@(posedge clk) disable iff (rst)
        upt |-> (upf && !dnf && $past(upf && !dnf)));
    // R7: same for down
    p_dn_run_r7: assert property (@(posedge clk) disable iff (rst)
        dnt |-> (dnf && !upf && $past(dnf && !upf)));
    // R9: a request is never followed at once by another
    p_clear_after_fire_r9: assert property (@(posedge clk) disable iff (rst)
        (upt || dnt) |=> hold);
endmodule

// File: rtl/dpll_phase_fsm.sv
module dpll_phase_fsm
    import dpll_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upt,
    input  logic   dnt,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst)       phase <= PH_MID;
        else if (upt)  phase <= rot_up(phase);
        else if (dnt)  phase <= rot_dn(phase);
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);
    p_rot_up_r8: assert property (@(posedge clk) disable iff (rst)
        upt |=> phase == {$past(phase[0]), $past(phase[2:1])});
    p_rot_dn_r8: assert property (@(posedge clk) disable iff (rst)
        dnt |=> phase == {$past(phase[1:0]), $past(phase[2])});
    p_hold_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (!upt && !dnt) |=> $stable(phase));
    p_reset_mid_r10: assert property (@(posedge clk)
        rst |=> phase == PH_MID);
endmodule

// File: rtl/dpll_cdr.sv
module dpll_cdr
    import dpll_pkg::*;
#(
    parameter int unsigned NBITS = DEF_NBITS,
    parameter int unsigned RUN   = DEF_RUN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OSR*NBITS-1:0] samp_i,
    output logic [NBITS-1:0]     data_o,
    output logic [2:0]           phase_o,
    output logic                 up_o,
    output logic                 dn_o,
    output logic                 hold_o
);
    localparam int unsigned W = OSR * NBITS;

    logic [W-1:0] cur_q, aligned;
    logic         prev_last_q;
    logic         upf, dnf;
    phase_e       phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '0;
            prev_last_q <= 1'b0;
        end else begin
            cur_q       <= samp_i;
            prev_last_q <= cur_q[W-1];
        end
    end

    dpll_window #(.NBITS(NBITS)) u_win (
        .cur(cur_q), .sp(prev_last_q), .sn(samp_i[0]),
        .phase(phase), .aligned(aligned)
    );

    dpll_detect #(.NBITS(NBITS)) u_det (
        .aligned(aligned), .upf(upf), .dnf(dnf)
    );

    dpll_filter #(.RUN(RUN)) u_flt (
        .clk(clk), .rst(rst), .upf(upf), .dnf(dnf),
        .upt(up_o), .dnt(dn_o), .hold(hold_o)
    );

    dpll_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .upt(up_o), .dnt(dn_o), .phase(phase)
    );

    for (genvar k = 0; k < NBITS; k++) begin : g_pick
        assign data_o[k] = aligned[OSR*k+1];
    end

    assign phase_o = phase;

    // R1: unshifted window hands out the middle held samples
    p_mid_pick_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MID) |-> (data_o[0] == cur_q[1] && data_o[NBITS-1] == cur_q[W-2]));
endmodule

// File: tb/tb_dpll_cdr.sv
module tb_dpll_cdr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] samp = '0;
    logic [3:0]  data_o;
    logic [2:0]  phase_o;
    logic        up_o, dn_o, hold_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    logic [11:0] m_cur  = '0;
    logic        m_prev = 1'b0;
    int          m_pidx = 1;   // 0 earlier, 1 unshifted, 2 later
    int          m_ucnt = 0;
    int          m_dcnt = 0;
    int          n_moves = 0;

    always #2 clk = ~clk;

    dpll_cdr dut (
        .clk(clk), .rst(rst), .samp_i(samp), .data_o(data_o),
        .phase_o(phase_o), .up_o(up_o), .dn_o(dn_o), .hold_o(hold_o)
    );

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] mk(input logic [2:0] p);
        logic [11:0] w;
        for (int n = 0; n < 4; n++) begin
            w[3*n]   = p[2];
            w[3*n+1] = p[1];
            w[3*n+2] = p[0];
        end
        return w;
    endfunction

    task automatic step(input logic [11:0] w);
        logic [13:0] ext;
        logic [11:0] a;
        logic [3:0]  ed;
        logic [2:0]  g;
        int nu, nd;
        logic upf, dnf, eu, edn;
        @(negedge clk);
        samp = w;
        #1;
        // ext[0] = previous last, ext[1..12] = held word, ext[13] = arriving first
        ext = {w[0], m_cur, m_prev};
        for (int n = 0; n < 12; n++) a[n] = ext[n + m_pidx];
        for (int k = 0; k < 4; k++) ed[k] = a[3*k+1];
        nu = 0; nd = 0;
        for (int n = 0; n < 4; n++) begin
            g = {a[3*n], a[3*n+1], a[3*n+2]};
            if (g == 3'b011 || g == 3'b100) nu++;
            if (g == 3'b001 || g == 3'b110) nd++;
        end
        upf = (nu >= 2);
        dnf = (nd >= 2);
        eu  = upf && !dnf && (m_ucnt == 3);
        edn = dnf && !upf && (m_dcnt == 3);
        if (m_pidx == 0)      chk("R3 data earlier shift", {8'h0, data_o}, {8'h0, ed});
        else if (m_pidx == 2) chk("R4 data later shift", {8'h0, data_o}, {8'h0, ed});
        else                  chk("R1 data unshifted", {8'h0, data_o}, {8'h0, ed});
        chk("R2 R8 phase", {9'h0, phase_o}, {9'h0, 3'b100 >> m_pidx});
        chk("R5 R6 R7 R9 filter", {9'h0, up_o, dn_o, hold_o},
            {9'h0, eu, edn, !(eu || edn)});
        // advance model to the next edge
        m_prev = m_cur[11];
        m_cur  = w;
        if (eu || edn) begin
            m_pidx  = eu ? (m_pidx + 1) % 3 : (m_pidx + 2) % 3;
            m_ucnt  = 0;
            m_dcnt  = 0;
            n_moves++;
        end else begin
            m_ucnt = (upf && !dnf) ? m_ucnt + 1 : 0;
            m_dcnt = (dnf && !upf) ? m_dcnt + 1 : 0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk("R10 reset phase", {9'h0, phase_o}, 12'h002);
        chk("R10 reset outputs", {7'h0, data_o, hold_o}, 12'h001);

        // R5: every group pattern in all four groups, long enough to trip the filter
        for (int p = 0; p < 8; p++)
            repeat (6) step(mk(3'(p)));

        // R7: two up groups and two down groups -> conflict is a hold
        repeat (6) step({mk(3'b011)[5:0], mk(3'b001)[5:0]});
        // R6: one up group only -> no majority
        repeat (6) step({mk(3'b000)[11:3], 3'b110});
        // R9: run of three broken, then a fresh run
        repeat (3) step(mk(3'b011));
        step(12'h000);
        repeat (5) step(mk(3'b011));
        // R8: walk phase in both directions
        repeat (20) step(mk(3'b100));
        repeat (20) step(mk(3'b110));
        repeat (20) step(mk(3'b001));

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i[7]) step(mk(lfsr[2:0]) ^ {11'h0, lfsr[5]});
            else      step({lfsr[11:0]});
        end

        // R8: the walks above must have produced moves
        chk("R8 moves seen", {11'h0, n_moves > 3}, 12'h001);
        finish_run();
    end
endmodule